// File: doc/BRIEF.md
# SD host interrupt status and reset unit

This block sits beside the command and data engines of an SD host controller and collects their one-cycle event pulses into a latched status vector. Two mask registers shape what happens to each event. The status-enable mask decides whether an event is recorded at all. The signal-enable mask decides which recorded bits may raise the interrupt line. Software clears recorded bits by writing ones. An event that lands in the same cycle as its own clear is kept.

The same register port carries three self-clearing reset requests: one for the whole unit, one for the command path and one for the data path. A request bit stays set, and its pulse output stays high, for a fixed number of cycles. The bit then drops without any action from software, which tells software that the targeted path has finished resetting. While a request is active, the status bits that belong to its path are held at zero. A whole-unit reset also clears both masks.

Top module: `sd_irq_reset_unit`

## Requirements
- R1: After the asynchronous reset, the status, status-enable, signal-enable and reset-control registers all read zero, and irq_o is low.
- R2: Event and status bit positions are: 0 command done, 1 command timeout, 2 command CRC error, 3 command index error, 4 transfer done, 5 data timeout, 6 data error, 7 buffer read ready, 8 buffer write ready. An event pulse sets its status bit on the next clock edge only when the bit at the same position in the status-enable register (address 1) is one. Buffer read ready and buffer write ready are masked independently of the other bits.
- R3: Writing to the status register (address 0) clears every bit written as one and leaves bits written as zero unchanged. Writing all ones clears all pending status.
- R4: If an enabled event and a write-one-to-clear of the same bit arrive in the same cycle, the bit stays set.
- R5: irq_o is the OR of status AND signal-enable (address 2), delayed by one register stage. A signal-enable of zero keeps irq_o low.
- R6: Writing one to bit 0 (whole unit), bit 1 (command path) or bit 2 (data path) of the reset-control register (address 3) sets that bit. The bit reads back as one, and its pulse output is high, for exactly RST_CYCLES (default 4) cycles, after which it clears by itself.
- R7: While the command-path reset is active, status bits 0 to 3 are cleared, and bits 4 to 8 keep their values.
- R8: While the data-path reset is active, status bits 4 to 8 are cleared, and bits 0 to 3 keep their values.
- R9: While the whole-unit reset is active, the status, status-enable and signal-enable registers are all cleared.
- R10: Clearing a status-enable bit does not clear a status bit that has already been latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 9 | Event pulses from the command and data engines, positions as in R2 |
| reg_addr_i | input | 2 | Register select: 0 status, 1 status-enable, 2 signal-enable, 3 reset-control |
| reg_wr_i | input | 1 | Write strobe, one cycle per write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the selected register, combinational |
| irq_o | output | 1 | Interrupt line |
| rst_all_o | output | 1 | Whole-unit reset pulse |
| rst_cmd_o | output | 1 | Command-path reset pulse |
| rst_dat_o | output | 1 | Data-path reset pulse |

## Verification
The assertions assume that evt_i, reg_wr_i, reg_addr_i and reg_wdata_i are known and change only between clock edges. They also assume that any event arriving during a path reset is meant to be discarded, which is why the event-sticking check excludes bits under reset. The stimulus drives every input on the falling clock edge and holds the event lines at zero while rst_n is low. Events are issued only as single-cycle pulses, and no register write is issued while the whole-unit reset is active, so the checks never depend on the precedence of those two.

// File: rtl/sdirq_pkg.sv
package sdirq_pkg;

  localparam int unsigned NUM_EVT    = 9;
  localparam int unsigned NUM_RST    = 3;
  localparam int unsigned REG_ADDR_W = 2;

  // event / status bit positions
  localparam int unsigned EV_CMD_DONE  = 0;
  localparam int unsigned EV_CMD_TOUT  = 1;
  localparam int unsigned EV_CMD_CRC   = 2;
  localparam int unsigned EV_CMD_IDX   = 3;
  localparam int unsigned EV_XFER_DONE = 4;
  localparam int unsigned EV_DAT_TOUT  = 5;
  localparam int unsigned EV_DAT_ERR   = 6;
  localparam int unsigned EV_BUF_RD    = 7;
  localparam int unsigned EV_BUF_WR    = 8;

  // reset request bit positions
  localparam int unsigned RQ_ALL  = 0;
  localparam int unsigned RQ_CMD  = 1;
  localparam int unsigned RQ_DATA = 2;

  localparam logic [NUM_EVT-1:0] CMD_GROUP  =
    NUM_EVT'((1 << (EV_CMD_IDX + 1)) - 1);
  localparam logic [NUM_EVT-1:0] DATA_GROUP = ~CMD_GROUP;

  typedef enum logic [REG_ADDR_W-1:0] {
    SEL_STATUS  = 2'd0,
    SEL_STAT_EN = 2'd1,
    SEL_SIG_EN  = 2'd2,
    SEL_RESET   = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/sdirq_rst_seq.sv
module sdirq_rst_seq #(
  parameter int unsigned RST_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic active_o
);

  localparam int unsigned CW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(RST_CYCLES - 1);

  logic          active_q, active_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    if (!active_q) begin
      if (start_i) begin
        active_d = 1'b1;
        cnt_d    = '0;
      end
    end else if (cnt_q == LAST) begin
      active_d = 1'b0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (active_q || start_i) begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
    end
  end

  assign active_o = active_q;

  // run-length monitor for the pulse width check
  localparam int unsigned RW = $clog2(RST_CYCLES + 1) + 1;
  logic [RW-1:0] chk_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        chk_run_q <= '0;
    else if (active_q) chk_run_q <= chk_run_q + 1'b1;
    else               chk_run_q <= '0;
  end

  // R6: a request stays active for exactly RST_CYCLES cycles
  a_r6_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_q) |-> (chk_run_q == RW'(RST_CYCLES)));

  // R6: a request written while idle is taken on the next edge
  a_r6_request_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !active_q) |=> active_q);

endmodule

// File: rtl/sdirq_mask_reg.sv
module sdirq_mask_reg #(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q_q, q_d;
  logic         en;

  assign en = wr_i | clr_i;

  always_comb begin
    if (clr_i) q_d = '0;
    else       q_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_q <= '0;
    else if (en) q_q <= q_d;
  end

  assign q_o = q_q;

endmodule

// File: rtl/sdirq_status_bank.sv
module sdirq_status_bank #(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] sten_i,
  input  logic [W-1:0] w1c_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] status_o
);

  logic [W-1:0] status_q, status_d, bit_en;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_comb begin
      bit_en[g] = clr_i[g] | w1c_i[g] | (evt_i[g] & sten_i[g]);
      if (clr_i[g])
        status_d[g] = 1'b0;
      else
        status_d[g] = (status_q[g] & ~w1c_i[g]) | (evt_i[g] & sten_i[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         status_q[g] <= 1'b0;
      else if (bit_en[g]) status_q[g] <= status_d[g];
    end
  end

  assign status_o = status_q;

  // R4: an enabled event outside a path reset always leaves its bit set
  a_r4_event_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(evt_i) & $past(sten_i) & ~$past(clr_i)) & ~status_q) == '0));

  // R2: a bit can only rise because of an enabled event
  a_r2_no_unlatched_rise: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~($past(evt_i) & $past(sten_i))) == '0));

  // R3: without event or clear a bit keeps its value
  a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_i == '0) && (w1c_i == '0) && (clr_i == '0)) |=> $stable(status_q));

endmodule

// File: rtl/sd_irq_reset_unit.sv
module sd_irq_reset_unit
  import sdirq_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned RST_CYCLES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_EVT-1:0]    evt_i,
  input  logic [REG_ADDR_W-1:0] reg_addr_i,
  input  logic                  reg_wr_i,
  input  logic [DATA_W-1:0]     reg_wdata_i,
  output logic [DATA_W-1:0]     reg_rdata_o,
  output logic                  irq_o,
  output logic                  rst_all_o,
  output logic                  rst_cmd_o,
  output logic                  rst_dat_o
);

  reg_sel_e           sel;
  logic               wr_status, wr_sten, wr_sigen, wr_reset;
  logic [NUM_EVT-1:0] w1c, grp_clr;
  logic [NUM_EVT-1:0] status_w, sten_w, sigen_w;
  logic [NUM_RST-1:0] rst_start, rst_active;
  logic               irq_q, irq_d;
  logic               unused_wdata;

  assign unused_wdata = ^reg_wdata_i[DATA_W-1:NUM_EVT];

  // register port decode
  always_comb begin
    sel       = reg_sel_e'(reg_addr_i);
    wr_status = reg_wr_i && (sel == SEL_STATUS);
    wr_sten   = reg_wr_i && (sel == SEL_STAT_EN);
    wr_sigen  = reg_wr_i && (sel == SEL_SIG_EN);
    wr_reset  = reg_wr_i && (sel == SEL_RESET);
    w1c       = wr_status ? reg_wdata_i[NUM_EVT-1:0] : '0;
  end

  // self-clearing reset requests
  for (genvar k = 0; k < NUM_RST; k++) begin : g_rst
    assign rst_start[k] = wr_reset & reg_wdata_i[k];
    sdirq_rst_seq #(.RST_CYCLES(RST_CYCLES)) i_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (rst_start[k]),
      .active_o (rst_active[k])
    );
  end

  // per-path status clearing
  always_comb begin
    grp_clr = '0;
    if (rst_active[RQ_ALL]) begin
      grp_clr = '1;
    end else begin
      if (rst_active[RQ_CMD])  grp_clr = grp_clr | CMD_GROUP;
      if (rst_active[RQ_DATA]) grp_clr = grp_clr | DATA_GROUP;
    end
  end

  sdirq_mask_reg #(.W(NUM_EVT)) i_sten (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (wr_sten),
    .wdata_i (reg_wdata_i[NUM_EVT-1:0]),
    .clr_i   (rst_active[RQ_ALL]),
    .q_o     (sten_w)
  );

  sdirq_mask_reg #(.W(NUM_EVT)) i_sigen (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (wr_sigen),
    .wdata_i (reg_wdata_i[NUM_EVT-1:0]),
    .clr_i   (rst_active[RQ_ALL]),
    .q_o     (sigen_w)
  );

  sdirq_status_bank #(.W(NUM_EVT)) i_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (evt_i),
    .sten_i   (sten_w),
    .w1c_i    (w1c),
    .clr_i    (grp_clr),
    .status_o (status_w)
  );

  // interrupt line, one register stage
  assign irq_d = |(status_w & sigen_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  // read mux
  always_comb begin
    reg_rdata_o = '0;
    unique case (sel)
      SEL_STATUS:  reg_rdata_o[NUM_EVT-1:0] = status_w;
      SEL_STAT_EN: reg_rdata_o[NUM_EVT-1:0] = sten_w;
      SEL_SIG_EN:  reg_rdata_o[NUM_EVT-1:0] = sigen_w;
      SEL_RESET:   reg_rdata_o[NUM_RST-1:0] = rst_active;
      default:     reg_rdata_o = '0;
    endcase
  end

  assign rst_all_o = rst_active[RQ_ALL];
  assign rst_cmd_o = rst_active[RQ_CMD];
  assign rst_dat_o = rst_active[RQ_DATA];

  // R5: nothing enabled and pending means the line is low next cycle
  a_r5_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_w & sigen_w) == '0) |=> !irq_o);

  // R5: an enabled pending bit raises the line next cycle
  a_r5_irq_raised: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_w & sigen_w) != '0) |=> irq_o);

  // R7: command reset empties the command group
  a_r7_cmd_group_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    rst_active[RQ_CMD] |=> ((status_w & CMD_GROUP) == '0));

  // R8: data reset empties the data group
  a_r8_data_group_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    rst_active[RQ_DATA] |=> ((status_w & DATA_GROUP) == '0));

  // R9: whole-unit reset empties status and both masks
  a_r9_all_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    rst_active[RQ_ALL] |=> (status_w == '0 && sten_w == '0 && sigen_w == '0));

endmodule

// File: tb/test_sd_irq_reset_unit.sv
module test_sd_irq_reset_unit;

  logic        clk;
  logic        rst_n;
  logic [8:0]  evt;
  logic [1:0]  addr;
  logic        wr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq, p_all, p_cmd, p_dat;

  int n_checks = 0;
  int n_fails  = 0;

  sd_irq_reset_unit i_sd_irq_reset_unit (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (evt),
    .reg_addr_i  (addr),
    .reg_wr_i    (wr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq),
    .rst_all_o   (p_all),
    .rst_cmd_o   (p_cmd),
    .rst_dat_o   (p_dat)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic fire(input logic [8:0] v);
    evt = v;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    for (int a = 0; a < 4; a++) begin
      reg_rd(2'(a), v);
      chk("R1 register after reset", v, 32'h0);
    end
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_enable_gating();
    logic [31:0] v;
    fire(9'h1FF);
    reg_rd(2'd0, v); chk("R2 all events masked", v, 32'h0);
    reg_wr(2'd1, 32'h07F);
    fire(9'h1FF);
    reg_rd(2'd0, v); chk("R2 buffer ready bits masked", v, 32'h07F);
    reg_wr(2'd1, 32'h1FF);
    fire(9'h100);
    reg_rd(2'd0, v); chk("R2 buffer write ready enabled alone", v, 32'h17F);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    reg_wr(2'd0, 32'h100);
    reg_rd(2'd0, v); chk("R3 clear bit 8", v, 32'h07F);
    reg_wr(2'd0, 32'h001);
    reg_rd(2'd0, v); chk("R3 clear bit 0", v, 32'h07E);
    reg_wr(2'd0, 32'h000);
    reg_rd(2'd0, v); chk("R3 zero write no effect", v, 32'h07E);
    reg_wr(2'd0, 32'hFFFF_FFFF);
    reg_rd(2'd0, v); chk("R3 all ones clears all", v, 32'h0);
  endtask

  task automatic t_sten_keeps_status();
    logic [31:0] v;
    fire(9'h002);
    reg_wr(2'd1, 32'h0);
    reg_rd(2'd0, v); chk("R10 latched bit kept after disable", v, 32'h002);
    reg_wr(2'd1, 32'h1FF);
    reg_wr(2'd0, 32'h1FF);
  endtask

  task automatic t_event_wins();
    logic [31:0] v;
    fire(9'h010);
    evt = 9'h010;
    reg_wr(2'd0, 32'h010);
    evt = '0;
    reg_rd(2'd0, v); chk("R4 event beats clear", v, 32'h010);
    reg_wr(2'd0, 32'h010);
    reg_rd(2'd0, v); chk("R4 clear alone works", v, 32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    fire(9'h002);
    @(negedge clk);
    chk("R5 zero signal-enable masks line", {31'b0, irq}, 32'h0);
    reg_wr(2'd2, 32'h002);
    chk("R5 line not yet raised", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R5 line raised after one stage", {31'b0, irq}, 32'h1);
    reg_wr(2'd0, 32'h002);
    chk("R5 line held one stage after clear", {31'b0, irq}, 32'h1);
    @(negedge clk);
    chk("R5 line dropped", {31'b0, irq}, 32'h0);
    reg_rd(2'd2, v); chk("R5 signal-enable readback", v, 32'h002);
    reg_wr(2'd2, 32'h0);
  endtask

  task automatic pulse_check(input int idx, input string req);
    logic [31:0] v;
    logic [2:0]  outs;
    reg_wr(2'd3, 32'(1 << idx));
    for (int c = 0; c < 4; c++) begin
      if (c != 0) @(negedge clk);
      reg_rd(2'd3, v);
      chk({req, " request bit reads set"}, v, 32'(1 << idx));
      outs = {p_dat, p_cmd, p_all};
      chk({req, " pulse output"}, {29'b0, outs}, 32'(1 << idx));
    end
    @(negedge clk);
    reg_rd(2'd3, v);
    chk({req, " request bit self-cleared"}, v, 32'h0);
    outs = {p_dat, p_cmd, p_all};
    chk({req, " pulse ended"}, {29'b0, outs}, 32'h0);
  endtask

  task automatic t_cmd_reset();
    logic [31:0] v;
    fire(9'h1FF);
    reg_rd(2'd0, v); chk("R2 all enabled events latched", v, 32'h1FF);
    pulse_check(1, "R6 command");
    reg_rd(2'd0, v); chk("R7 command group cleared only", v, 32'h1F0);
  endtask

  task automatic t_data_reset();
    logic [31:0] v;
    fire(9'h1FF);
    pulse_check(2, "R6 data");
    reg_rd(2'd0, v); chk("R8 data group cleared only", v, 32'h00F);
  endtask

  task automatic t_all_reset();
    logic [31:0] v;
    reg_wr(2'd2, 32'h0F0);
    fire(9'h1FF);
    pulse_check(0, "R6 whole unit");
    reg_rd(2'd0, v); chk("R9 status cleared", v, 32'h0);
    reg_rd(2'd1, v); chk("R9 status-enable cleared", v, 32'h0);
    reg_rd(2'd2, v); chk("R9 signal-enable cleared", v, 32'h0);
    @(negedge clk);
    chk("R9 irq low after whole reset", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; evt = '0; addr = '0; wr = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_enable_gating();
    t_w1c();
    t_sten_keeps_status();
    t_event_wins();
    t_irq();
    t_cmd_reset();
    t_data_reset();
    t_all_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule